// File: doc/BRIEF.md
# BCD Alarm Repeat Controller

This block holds four alarm registers (seconds, minutes, hours and day of month) and compares them against a running BCD time of day supplied from outside. When the alarm condition holds on a one-second tick, the block raises its interrupt output for exactly one clock cycle. Bit 7 of each alarm register is a repeat flag. The combination of the four flags selects how often the alarm recurs: monthly, daily, hourly, every minute or every second.

Alarm values arrive through a single-byte write port that selects one register by a two-bit code. Every write is range-checked as BCD before it is taken. An out-of-range value is dropped and the register keeps its old contents. The time-of-day counter, interrupt steering and bus decoding all sit around this block.

Top module: `bcd_alarm_repeat`

## Requirements
- R1: A synchronous reset clears all four alarm registers to 0x00 and holds `alarmIrq` low while it is asserted. With all registers at zero, a tick at time 00:00:00 on date 0 fires the alarm and a tick at second 01 does not.
- R2: Write select codes are 0 = seconds, 1 = minutes, 2 = hours, 3 = date. For select 0 or 1, the value v = 10·bits[6:4] + bits[3:0] is computed. If v ≤ 59, the write is accepted and the whole byte is stored. Otherwise the register is left unchanged.
- R3: For select 2, v = 10·bits[5:4] + bits[3:0]. The write is accepted only if v ≤ 23. A rejected write leaves the register unchanged.
- R4: For select 3, v = 10·bits[5:4] + bits[3:0]. The write is accepted only if v is nonzero. A rejected write leaves the register unchanged.
- R5: The fields are compared as follows: seconds and minutes use register bits [6:0], hours and date use bits [5:0]. If all four bit-7 flags are clear, the alarm fires on a tick only when seconds, minutes, hours and date all match.
- R6: If only the date flag is set, the alarm fires on a tick when seconds, minutes and hours match.
- R7: If the date and hours flags are set and the minutes and seconds flags are clear, the alarm fires on a tick when seconds and minutes match.
- R8: If the date, hours and minutes flags are set and the seconds flag is clear, the alarm fires on a tick when seconds match.
- R9: Any other flag combination fires the alarm on every tick.
- R10: `alarmIrq` goes high in the clock cycle after the firing tick and stays high for exactly one cycle. It never rises without a tick in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Alarm register write strobe |
| wrSel | input | 2 | Register select: 0 seconds, 1 minutes, 2 hours, 3 date |
| wrData | input | 8 | Write byte: repeat flag in bit 7, BCD value below it |
| secTick | input | 1 | One-cycle pulse once per second from the time counter |
| nowSec | input | 7 | Current seconds, BCD |
| nowMin | input | 7 | Current minutes, BCD |
| nowHour | input | 6 | Current hours, BCD |
| nowDate | input | 6 | Current day of month, BCD |
| alarmIrq | output | 1 | Single-cycle alarm interrupt pulse |

## Verification
A corrupted alarm register, or a write that was wrongly accepted or rejected, shows up as a missing or extra pulse on the next tick whose repeat mode compares that field. The bench therefore rewrites a known baseline before every candidate byte and then ticks at both the old time and the candidate time. A wrong decode of the flag combination appears on the very first tick in that mode, so every one of the sixteen combinations is swept against a matching time and four single-field mismatches. A stuck or stretched interrupt register is visible one cycle after a tick.

// File: rtl/bcd_alarm_pkg.sv
`timescale 1ns/1ps
package bcd_alarm_pkg;

  localparam int REG_W      = 8;
  localparam int NUM_FIELDS = 4;
  localparam int SEL_W      = $clog2(NUM_FIELDS);
  localparam int SEC_W      = 7;
  localparam int MIN_W      = 7;
  localparam int HOUR_W     = 6;
  localparam int DATE_W     = 6;

  typedef enum logic [SEL_W-1:0] {
    SEL_SEC  = 2'd0,
    SEL_MIN  = 2'd1,
    SEL_HOUR = 2'd2,
    SEL_DATE = 2'd3
  } fieldSel_e;

  typedef enum logic [2:0] {
    RPT_MONTH,
    RPT_DAY,
    RPT_HOUR,
    RPT_MINUTE,
    RPT_SECOND
  } repeatMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_FIELDS-1:0] load;
  } ctlStrobe_t;

  function automatic int fieldWidth(input int idx);
    case (idx)
      0:       return SEC_W;
      1:       return MIN_W;
      2:       return HOUR_W;
      default: return DATE_W;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] fieldLimit(input int idx);
    case (idx)
      0, 1:    return 8'd59;
      2:       return 8'd23;
      default: return 8'd99;
    endcase
  endfunction

  // tens nibble times ten plus units nibble, over the low w bits
  function automatic logic [REG_W-1:0] bcdValue(input logic [REG_W-1:0] raw, input int w);
    logic [REG_W-1:0] kept;
    kept = raw & REG_W'((9'd1 << w) - 9'd1);
    return REG_W'(kept[7:4]) * 8'd10 + REG_W'(kept[3:0]);
  endfunction

endpackage

// File: rtl/bcd_alarm_dp.sv
`timescale 1ns/1ps
module bcd_alarm_dp
  import bcd_alarm_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst,
  input  ctlStrobe_t                       strobe,
  input  logic [REG_W-1:0]                 wrData,
  input  logic [SEC_W-1:0]                 nowSec,
  input  logic [MIN_W-1:0]                 nowMin,
  input  logic [HOUR_W-1:0]                nowHour,
  input  logic [DATE_W-1:0]                nowDate,
  output logic [NUM_FIELDS-1:0][REG_W-1:0] almRegs,
  output logic [NUM_FIELDS-1:0]            fieldMatch,
  output logic [NUM_FIELDS-1:0]            maskBits
);

  logic [NUM_FIELDS-1:0][REG_W-1:0] nowVec;

  assign nowVec[0] = REG_W'(nowSec);
  assign nowVec[1] = REG_W'(nowMin);
  assign nowVec[2] = REG_W'(nowHour);
  assign nowVec[3] = REG_W'(nowDate);

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (rst)                 almRegs[i] <= '0;
      else if (strobe.load[i]) almRegs[i] <= wrData;
    end
  end

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
    localparam int W = fieldWidth(gi);
    assign fieldMatch[gi] = (almRegs[gi][W-1:0] == nowVec[gi][W-1:0]);
    assign maskBits[gi]   = almRegs[gi][REG_W-1];
  end

endmodule

// File: rtl/bcd_alarm_ctl.sv
`timescale 1ns/1ps
module bcd_alarm_ctl
  import bcd_alarm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrEn,
  input  logic [SEL_W-1:0]      wrSel,
  input  logic [REG_W-1:0]      wrData,
  input  logic                  secTick,
  input  logic [NUM_FIELDS-1:0] maskBits,
  input  logic [NUM_FIELDS-1:0] fieldMatch,
  output ctlStrobe_t            strobe,
  output logic                  alarmIrq
);

  logic [REG_W-1:0] decoded;
  logic             wrOk;
  repeatMode_e      mode;
  logic             hit;

  // write range check
  always_comb begin
    decoded = bcdValue(wrData, fieldWidth(int'(wrSel)));
    if (wrSel == SEL_DATE) wrOk = (decoded != '0);
    else                   wrOk = (decoded <= fieldLimit(int'(wrSel)));
    strobe.load = '0;
    if (wrEn && wrOk) strobe.load[wrSel] = 1'b1;
  end

  // graded repeat decode: flags ordered {date, hour, min, sec}
  always_comb begin
    case ({maskBits[3], maskBits[2], maskBits[1], maskBits[0]})
      4'b0000: mode = RPT_MONTH;
      4'b1000: mode = RPT_DAY;
      4'b1100: mode = RPT_HOUR;
      4'b1110: mode = RPT_MINUTE;
      default: mode = RPT_SECOND;
    endcase
  end

  always_comb begin
    case (mode)
      RPT_MONTH:  hit = &fieldMatch;
      RPT_DAY:    hit = &fieldMatch[2:0];
      RPT_HOUR:   hit = &fieldMatch[1:0];
      RPT_MINUTE: hit = fieldMatch[0];
      default:    hit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) alarmIrq <= 1'b0;
    else     alarmIrq <= secTick && hit;
  end

endmodule

// File: rtl/bcd_alarm_repeat.sv
`timescale 1ns/1ps
module bcd_alarm_repeat
  import bcd_alarm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [REG_W-1:0]   wrData,
  input  logic               secTick,
  input  logic [SEC_W-1:0]   nowSec,
  input  logic [MIN_W-1:0]   nowMin,
  input  logic [HOUR_W-1:0]  nowHour,
  input  logic [DATE_W-1:0]  nowDate,
  output logic               alarmIrq
);

  ctlStrobe_t                       strobe;
  logic [NUM_FIELDS-1:0][REG_W-1:0] almRegs;
  logic [NUM_FIELDS-1:0]            fieldMatch;
  logic [NUM_FIELDS-1:0]            maskBits;

  bcd_alarm_ctl uCtl (
    .clk        (clk),
    .rst        (rst),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .wrData     (wrData),
    .secTick    (secTick),
    .maskBits   (maskBits),
    .fieldMatch (fieldMatch),
    .strobe     (strobe),
    .alarmIrq   (alarmIrq)
  );

  bcd_alarm_dp uDp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .wrData     (wrData),
    .nowSec     (nowSec),
    .nowMin     (nowMin),
    .nowHour    (nowHour),
    .nowDate    (nowDate),
    .almRegs    (almRegs),
    .fieldMatch (fieldMatch),
    .maskBits   (maskBits)
  );

endmodule

// File: rtl/bcd_alarm_repeat_chk.sv
`timescale 1ns/1ps
module bcd_alarm_repeat_chk
  import bcd_alarm_pkg::*;
(
  input logic                             clk,
  input logic                             rst,
  input logic                             wrEn,
  input logic [SEL_W-1:0]                 wrSel,
  input logic [REG_W-1:0]                 wrData,
  input logic                             secTick,
  input logic                             alarmIrq,
  input logic [NUM_FIELDS-1:0][REG_W-1:0] almRegs
);

  logic [REG_W-1:0] tens7, tens6;
  logic [3:0]       flags;
  logic             anyRate;

  assign tens7   = REG_W'(wrData[6:4]) * 8'd10 + REG_W'(wrData[3:0]);
  assign tens6   = REG_W'(wrData[5:4]) * 8'd10 + REG_W'(wrData[3:0]);
  assign flags   = {almRegs[3][7], almRegs[2][7], almRegs[1][7], almRegs[0][7]};
  assign anyRate = !(flags == 4'b0000 || flags == 4'b1000 ||
                     flags == 4'b1100 || flags == 4'b1110);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !alarmIrq);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (almRegs == '0));
  // R2
  sec_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrSel == 2'd0 && tens7 > 8'd59) |=> $stable(almRegs[0]));
  // R2
  min_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrSel == 2'd1 && tens7 > 8'd59) |=> $stable(almRegs[1]));
  // R3
  hour_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrSel == 2'd2 && tens6 > 8'd23) |=> $stable(almRegs[2]));
  // R4
  date_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrSel == 2'd3 && tens6 == 8'd0) |=> $stable(almRegs[3]));
  // R9
  every_second_chk: assert property (@(posedge clk) disable iff (rst)
    (secTick && anyRate) |=> alarmIrq);
  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    alarmIrq |=> !alarmIrq);
  // R10
  tick_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alarmIrq) |-> $past(secTick));

endmodule

bind bcd_alarm_repeat bcd_alarm_repeat_chk uChk (
  .clk      (clk),
  .rst      (rst),
  .wrEn     (wrEn),
  .wrSel    (wrSel),
  .wrData   (wrData),
  .secTick  (secTick),
  .alarmIrq (alarmIrq),
  .almRegs  (almRegs)
);

// File: tb/bcd_alarm_repeat_test.sv
`timescale 1ns/1ps
module bcd_alarm_repeat_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [7:0] wrData = '0;
  logic       secTick = 1'b0;
  logic [6:0] nowSec = '0;
  logic [6:0] nowMin = '0;
  logic [5:0] nowHour = '0;
  logic [5:0] nowDate = '0;
  logic       alarmIrq;

  int nChecks = 0;
  int nFail   = 0;
  logic [7:0] mReg [4];

  always #2 clk = ~clk;

  bcd_alarm_repeat uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .secTick(secTick), .nowSec(nowSec), .nowMin(nowMin), .nowHour(nowHour),
    .nowDate(nowDate), .alarmIrq(alarmIrq)
  );

  task automatic check(input logic act, input logic exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0b expected %0b", what, act, exp);
    end
  endtask

  function automatic int dec(input logic [7:0] v, input int w);
    if (w == 7) return int'(v[6:4]) * 10 + int'(v[3:0]);
    return int'(v[5:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic accepts(input int sel, input logic [7:0] v);
    case (sel)
      0, 1:    return dec(v, 7) <= 59;
      2:       return dec(v, 6) <= 23;
      default: return dec(v, 6) != 0;
    endcase
  endfunction

  function automatic logic expFire(input logic [6:0] s, input logic [6:0] m,
                                   input logic [5:0] h, input logic [5:0] d);
    logic eqS, eqM, eqH, eqD;
    eqS = (mReg[0][6:0] == s);
    eqM = (mReg[1][6:0] == m);
    eqH = (mReg[2][5:0] == h);
    eqD = (mReg[3][5:0] == d);
    case ({mReg[3][7], mReg[2][7], mReg[1][7], mReg[0][7]})
      4'b0000: return eqS & eqM & eqH & eqD;
      4'b1000: return eqS & eqM & eqH;
      4'b1100: return eqS & eqM;
      4'b1110: return eqS;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string modeTag();
    case ({mReg[3][7], mReg[2][7], mReg[1][7], mReg[0][7]})
      4'b0000: return "R5 monthly";
      4'b1000: return "R6 daily";
      4'b1100: return "R7 hourly";
      4'b1110: return "R8 per-minute";
      default: return "R9 every-second";
    endcase
  endfunction

  // starts and ends on a falling edge
  task automatic wr(input int sel, input logic [7:0] v);
    wrEn = 1'b1; wrSel = 2'(sel); wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
    if (accepts(sel, v)) mReg[sel] = v;
  endtask

  task automatic tickAt(input logic [6:0] s, input logic [6:0] m,
                        input logic [5:0] h, input logic [5:0] d, input string tag);
    logic exp;
    exp = expFire(s, m, h, d);
    nowSec = s; nowMin = m; nowHour = h; nowDate = d; secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
    check(alarmIrq, exp, tag);
    @(negedge clk);
    check(alarmIrq, 1'b0, "R10 pulse ends after one cycle");
  endtask

  initial begin
    #800000;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mReg[i] = 8'h00;
    @(negedge clk);
    secTick = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(alarmIrq, 1'b0, "R1 output low during reset");
    end
    secTick = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    tickAt(7'h00, 7'h00, 6'h00, 6'h00, "R1 cleared registers match zero time");
    tickAt(7'h01, 7'h00, 6'h00, 6'h00, "R1 cleared registers miss second 01");

    // R10: no tick, no pulse, even in every-second mode
    wr(0, 8'h80); wr(1, 8'h80); wr(2, 8'h80); wr(3, 8'h81);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(alarmIrq, 1'b0, "R10 no pulse without tick");
    end

    // R2 seconds sweep in per-minute mode
    wr(1, 8'h80); wr(2, 8'h80); wr(3, 8'h81);
    for (int v = 0; v < 256; v++) begin
      wr(0, 8'h00); wr(0, 8'(v));
      tickAt(mReg[0][6:0], 7'h00, 6'h00, 6'h01, "R2 seconds write, stored value");
      tickAt(7'(v), 7'h00, 6'h00, 6'h01, "R2 seconds write, candidate value");
    end

    // R2 minutes sweep in hourly mode
    wr(0, 8'h00); wr(2, 8'h80); wr(3, 8'h81);
    for (int v = 0; v < 256; v++) begin
      wr(1, 8'h00); wr(1, 8'(v));
      tickAt(7'h00, mReg[1][6:0], 6'h00, 6'h01, "R2 minutes write, stored value");
      tickAt(7'h00, 7'(v), 6'h00, 6'h01, "R2 minutes write, candidate value");
    end

    // R3 hours sweep in daily mode
    wr(0, 8'h00); wr(1, 8'h00); wr(3, 8'h81);
    for (int v = 0; v < 256; v++) begin
      wr(2, 8'h00); wr(2, 8'(v));
      tickAt(7'h00, 7'h00, mReg[2][5:0], 6'h01, "R3 hours write, stored value");
      tickAt(7'h00, 7'h00, 6'(v), 6'h01, "R3 hours write, candidate value");
    end

    // R4 date sweep in monthly mode
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00);
    for (int v = 0; v < 256; v++) begin
      wr(3, 8'h01); wr(3, 8'(v));
      tickAt(7'h00, 7'h00, 6'h00, mReg[3][5:0], "R4 date write, stored value");
      tickAt(7'h00, 7'h00, 6'h00, 6'(v), "R4 date write, candidate value");
    end

    // R5..R9 all sixteen flag combinations
    for (int k = 0; k < 16; k++) begin
      wr(0, {k[0], 7'h25});
      wr(1, {k[1], 7'h43});
      wr(2, {k[2], 7'h17});
      wr(3, {k[3], 7'h28});
      for (int p = 0; p < 5; p++) begin
        logic [6:0] s, m;
        logic [5:0] h, d;
        s = 7'h25; m = 7'h43; h = 6'h17; d = 6'h28;
        if (p == 1) s = s ^ 7'h01;
        if (p == 2) m = m ^ 7'h01;
        if (p == 3) h = h ^ 6'h01;
        if (p == 4) d = d ^ 6'h01;
        tickAt(s, m, h, d, modeTag());
      end
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule